// File: doc/BRIEF.md
# BCD to Densely Packed Decimal Converter

This block turns packed binary coded decimal digits into densely packed decimal declets. A 64-bit operand is split into two independent 32-bit words. In each word, the six digits in the low 24 bits are compressed into two 10-bit declets. Each declet holds three decimal digits in ten bits.

The conversion is combinational. One output register captures the packed result on the clock edge after an input strobe, and raises an output strobe in the same cycle. A core can use the block as the execution stage of a fixed-point instruction that reads one source register and writes one destination register. In that use, the fixed-point opcode is 31 and the extended opcode is 314, and the third register field is unused.

Top module: `bcd_dpd_pack`

## Requirements
- R1: The two 32-bit halves of `in_data` are converted independently. Bits 31:0 of the input produce bits 31:0 of `out_data`, and bits 63:32 produce bits 63:32.
- R2: Within a word, the most significant digit sits at bits 23:20 and the least significant digit at bits 3:0. Bits 19:10 of the output half encode the digits from bits 23:12, and bits 9:0 encode the digits from bits 11:0. For example, word 0x00123456 yields 0x00028E56, and 0x00999999 yields 0x0003FCFF.
- R3: Bits 31:24 of each input word have no effect on the result.
- R4: Bits 31:20 of each output half are always zero.
- R5: A digit field above 9 is encoded as its value ANDed with binary 1001. So A and C become 8, B and D become 9, and 0xFFFFFF encodes the same as 999999.
- R6: Number the declet bits 9 to 0. When the hundreds digit H, tens digit T and units digit U are all 0 to 7, the declet is {H[2:0], T[2:0], 0, U[2:0]}.
- R7: When any of the three digits is 8 or 9, bit 3 of the declet is 1 and bit 0 is U[0]. The other bits (9..4 and 2..1) depend on which digits are large:
  - U only: H[2:0], T[2:0], 00.
  - T only: H[2:0], U[2:1], T[0], 01.
  - H only: U[2:1], H[0], T[2:0], 10.
  - H and T: U[2:1], H[0], 00, T[0], 11.
  - H and U: T[2:1], H[0], 01, T[0], 11.
  - T and U: H[2:0], 10, T[0], 11.
  - all three: 00, H[0], 11, T[0], 11.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_data` then holds the conversion of the `in_data` sampled with that strobe.
- R9: While `in_valid` is low, `out_data` keeps its previous value, whatever `in_data` does.
- R10: A synchronous active-high `rst` clears `out_data` to zero and `out_valid` to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source operand strobe |
| in_data | input | 64 | Two words of packed BCD digits |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 64 | Two words of packed declets |

## Verification
The block holds only the output register and its strobe. A wrong state shows at the ports on the first edge after the offending input: a bad encoding, a swapped half or a stray upper bit in the result, or a strobe out of step with its input. A register that loads without a strobe shows up while the input is idle, as a result that changes between strobes. Every valid three-digit combination is checked in both declet positions and both halves. Each invalid code is checked in every digit position, so a fault in the reduction of invalid digits shows up in the first result it affects.

// File: rtl/bcd_dpd_pack.sv
module bcd_dpd_pack #(
  parameter int WORDS  = 2,
  parameter int WORD_W = 32,
  parameter int DIGITS = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [WORDS*WORD_W-1:0]   in_data,
  output logic                      out_valid,
  output logic [WORDS*WORD_W-1:0]   out_data
);
  localparam int DATA_W = WORDS * WORD_W;
  localparam int TRIPS  = DIGITS / 3;
  localparam int BCD_W  = 4 * DIGITS;
  localparam int PACK_W = 10 * TRIPS;

  function automatic logic [3:0] fix_digit(input logic [3:0] d);
    return (d > 4'd9) ? (d & 4'b1001) : d;
  endfunction

  function automatic logic [9:0] declet(input logic [3:0] h, input logic [3:0] t,
                                        input logic [3:0] u);
    logic [9:0] r;
    case ({h[3], t[3], u[3]})
      3'b000:  r = {h[2:0], t[2:0], 1'b0, u[2:0]};
      3'b001:  r = {h[2:0], t[2:0], 1'b1, 2'b00, u[0]};
      3'b010:  r = {h[2:0], u[2:1], t[0], 1'b1, 2'b01, u[0]};
      3'b100:  r = {u[2:1], h[0], t[2:0], 1'b1, 2'b10, u[0]};
      3'b110:  r = {u[2:1], h[0], 2'b00, t[0], 1'b1, 2'b11, u[0]};
      3'b101:  r = {t[2:1], h[0], 2'b01, t[0], 1'b1, 2'b11, u[0]};
      3'b011:  r = {h[2:0], 2'b10, t[0], 1'b1, 2'b11, u[0]};
      default: r = {2'b00, h[0], 2'b11, t[0], 1'b1, 2'b11, u[0]};
    endcase
    return r;
  endfunction

  logic [DATA_W-1:0] packed_nxt;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam int IB = w * WORD_W;
    logic unused_hi;
    assign unused_hi = ^in_data[IB+BCD_W +: WORD_W-BCD_W];
    assign packed_nxt[IB+PACK_W +: WORD_W-PACK_W] = '0;
    for (genvar j = 0; j < TRIPS; j++) begin : g_trip
      assign packed_nxt[IB+10*j +: 10] =
        declet(fix_digit(in_data[IB+12*j+8 +: 4]),
               fix_digit(in_data[IB+12*j+4 +: 4]),
               fix_digit(in_data[IB+12*j   +: 4]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= packed_nxt;
    end
  end
endmodule

// File: rtl/bcd_dpd_pack_chk.sv
module bcd_dpd_pack_chk #(
  parameter int WORDS  = 2,
  parameter int WORD_W = 32,
  parameter int DIGITS = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [WORDS*WORD_W-1:0] in_data,
  input logic                    out_valid,
  input logic [WORDS*WORD_W-1:0] out_data
);
  localparam int BCD_W  = 4 * DIGITS;
  localparam int PACK_W = 10 * (DIGITS / 3);

  a_r8_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r8_strobe_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  for (genvar w = 0; w < WORDS; w++) begin : g_w
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_data[w*WORD_W+PACK_W +: WORD_W-PACK_W] == '0);

    a_r6_zero_word: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_data[w*WORD_W +: BCD_W] == '0)
        |=> out_data[w*WORD_W +: PACK_W] == '0);
  end
endmodule

bind bcd_dpd_pack bcd_dpd_pack_chk #(.WORDS(WORDS), .WORD_W(WORD_W), .DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data));

// File: tb/test_bcd_dpd_pack.sv
module test_bcd_dpd_pack;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int total = 0;
  int bad = 0;

  bcd_dpd_pack i_bcd_dpd_pack (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] ref_dig(input logic [3:0] d);
    if (d >= 4'd10) return {1'b1, 2'b00, d[0]};
    return d;
  endfunction

  function automatic logic [9:0] ref_dec(input logic [3:0] hi, input logic [3:0] mi,
                                         input logic [3:0] lo);
    logic [3:0] a, b, c;
    logic [9:0] r;
    a = ref_dig(hi); b = ref_dig(mi); c = ref_dig(lo);
    r = '0;
    if (!a[3] && !b[3] && !c[3]) begin
      r = {a[2:0], b[2:0], 1'b0, c[2:0]};
    end else begin
      r[3] = 1'b1; r[0] = c[0];
      if (a[3] && b[3] && c[3])  begin r[9:7] = {2'b00, a[0]}; r[6:4] = {2'b11, b[0]}; r[2:1] = 2'b11; end
      else if (b[3] && c[3])     begin r[9:7] = a[2:0]; r[6:4] = {2'b10, b[0]}; r[2:1] = 2'b11; end
      else if (a[3] && c[3])     begin r[9:7] = {b[2:1], a[0]}; r[6:4] = {2'b01, b[0]}; r[2:1] = 2'b11; end
      else if (a[3] && b[3])     begin r[9:7] = {c[2:1], a[0]}; r[6:4] = {2'b00, b[0]}; r[2:1] = 2'b11; end
      else if (a[3])             begin r[9:7] = {c[2:1], a[0]}; r[6:4] = b[2:0]; r[2:1] = 2'b10; end
      else if (b[3])             begin r[9:7] = a[2:0]; r[6:4] = {c[2:1], b[0]}; r[2:1] = 2'b01; end
      else                       begin r[9:7] = a[2:0]; r[6:4] = b[2:0]; r[2:1] = 2'b00; end
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_word(input logic [31:0] x);
    return {12'h000, ref_dec(x[23:20], x[19:16], x[15:12]), ref_dec(x[11:8], x[7:4], x[3:0])};
  endfunction

  function automatic logic [63:0] ref_all(input logic [63:0] x);
    return {ref_word(x[63:32]), ref_word(x[31:0])};
  endfunction

  function automatic logic [11:0] to_bcd3(input int n);
    return {4'(n / 100), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_check(input string req, input logic [63:0] x, input logic [63:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_data = x;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_valid, out_data}, {1'b1, exp});
  endtask

  task automatic t_reset;
    check("R10 reset state", {out_valid, out_data}, 65'h0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_known;
    apply_check("R2 digit order", {32'h00999999, 32'h00123456}, {32'h0003FCFF, 32'h00028E56});
    apply_check("R1 halves independent", {32'h00000000, 32'h00123456}, {32'h00000000, 32'h00028E56});
    apply_check("R1 halves swapped", {32'h00123456, 32'h00000000}, {32'h00028E56, 32'h00000000});
    apply_check("R5 all invalid", {32'h00FFFFFF, 32'h00ABCDEF}, {32'h0003FCFF, ref_word(32'h00898989)});
  endtask

  task automatic t_sweep;
    for (int n = 0; n < 1000; n++) begin
      logic [63:0] x;
      x = {8'h3C, to_bcd3((n * 7) % 1000), to_bcd3((n * 13 + 5) % 1000),
           8'h00, to_bcd3(n), to_bcd3(999 - n)};
      apply_check("R6/R7 sweep", x, ref_all(x));
    end
  endtask

  task automatic t_invalid;
    for (int code = 10; code < 16; code++) begin
      for (int pos = 0; pos < 6; pos++) begin
        logic [31:0] w;
        logic [31:0] wf;
        w = 32'h00555555;
        w[4*pos +: 4] = 4'(code);
        wf = w;
        wf[4*pos +: 4] = 4'(code) & 4'b1001;
        apply_check("R5 invalid digit", {w, w}, {ref_word(wf), ref_word(wf)});
      end
    end
  endtask

  task automatic t_upper;
    logic [63:0] base;
    base = {32'h00908172, 32'h00384756};
    apply_check("R3 upper bytes set", base | 64'hFF000000_A5000000, ref_all(base));
    apply_check("R3 upper bytes other", base | 64'h5A000000_FF000000, ref_all(base));
    check("R4 upper result zero", {1'b0, out_data & 64'hFFF00000_FFF00000}, 65'h0);
  endtask

  task automatic t_hold;
    logic [63:0] x;
    x = {32'h00086420, 32'h00975310};
    apply_check("R8 result", x, ref_all(x));
    for (int k = 0; k < 3; k++) begin
      in_data = 64'h00111111_00222222 + 64'(k);
      @(negedge clk);
      check("R9 hold while idle", {out_valid, out_data}, {1'b0, ref_all(x)});
    end
    check("R8 strobe low when idle", {64'h0, out_valid}, 65'h0);
  endtask

  task automatic t_midreset;
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_data = 64'h00123456_00123456;
    @(negedge clk);
    check("R10 reset clears", {out_valid, out_data}, 65'h0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R10 stays clear", {out_valid, out_data}, 65'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_known();
    t_sweep();
    t_invalid();
    t_upper();
    t_hold();
    t_midreset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule